// File: doc/BRIEF.md
# Automatic Gain Control Loop Controller

This block closes a gain loop around an analog-to-digital converter. It watches the stream of signed converter samples and forms a running power estimate. From that estimate it decides when to step a digital gain code that drives an external variable-gain amplifier in front of the converter. The aim is to keep the converter input near a programmed target level.

Each valid sample is squared and averaged in a first-order leaky integrator. A configuration shift sets the integrator's time constant. The averaged power is turned into a base-2 logarithm with three fraction bits, and the programmed threshold is subtracted from it. The gain code steps only when this error leaves a programmed deadband. After a step in one direction, the same direction stays blocked until the error has come back inside the deadband by a programmed hysteresis margin. This keeps the amplifier from chattering around the target. The gain code is clamped at both ends. A one-cycle strobe marks every change of the code.

Top module: `agc_loop`

## Requirements
- R1: While `rst_ni` is low and on its release, `gain_o` equals the parameter `INIT_GAIN` (default 8) and `gain_upd_o` is 0.
- R2: A cycle with `clear_i` high loads `cfg_init_gain_i` into the gain code, empties the power integrator, re-enables both step directions and cancels any pending decision, all without a strobe. `clear_i` takes priority over a sample presented in the same cycle.
- R3: On each valid sample `s`, the integrator `P` becomes `P + floor((s*s - P) / 2^k)`, where `k` is `cfg_shift_i` (0..15). With `k` = 0, `P` equals the latest square.
- R4: The level code is 0 for `P` = 0. Otherwise it is `8*m + f`, where `m` is the index of the highest set bit of `P` and `f` is the three bits just below that bit (zeros where they fall below bit 0). The error is the level code minus `cfg_thresh_i`, in the same 1/8-octave units.
- R5: One clock edge after the integrator takes a sample, a decision is made. If the error is greater than `cfg_deadband_i` and the downward direction is enabled, the downward direction is disabled and the gain code decreases by one.
- R6: In the same decision, if the error is less than minus `cfg_deadband_i` and the upward direction is enabled, the upward direction is disabled and the gain code increases by one.
- R7: An error between minus `cfg_deadband_i` and plus `cfg_deadband_i`, inclusive, never changes the gain code.
- R8: The downward direction is enabled again only when a decision sees an error at or below `cfg_deadband_i - cfg_hyst_i`. The upward direction is enabled again only when a decision sees an error at or above `cfg_hyst_i - cfg_deadband_i`.
- R9: The gain code never goes below 0 or above 15. A step that would pass either end still uses up its direction, but leaves the code unchanged and raises no strobe.
- R10: `gain_upd_o` is high for exactly the cycles in which `gain_o` has just changed by a step of one. It never marks a change made by `clear_i`.
- R11: A cycle with `sample_valid_i` low leaves the integrator and the gain code untouched, whatever value `sample_i` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous loop restart |
| sample_i | input | 14 | Converter sample, two's complement |
| sample_valid_i | input | 1 | Qualifies `sample_i` |
| cfg_shift_i | input | 4 | Integrator shift (time constant) |
| cfg_thresh_i | input | 8 | Target level, 1/8-octave units |
| cfg_deadband_i | input | 8 | Deadband half-width |
| cfg_hyst_i | input | 8 | Re-enable margin inside the deadband |
| cfg_init_gain_i | input | 4 | Gain code loaded by `clear_i` |
| gain_o | output | 4 | Gain code to the amplifier |
| gain_upd_o | output | 1 | One-cycle strobe on each gain change |

## Verification
A sample set up before edge k enters the integrator at edge k. The decision it causes changes `gain_o` and `gain_upd_o` at edge k+1. A clear acts at its own edge. The bench drives inputs at the falling edge and advances a reference model by one edge per cycle in that same order. It compares both outputs at the falling edge after every rising edge, so each result is checked in exactly the cycle it is due. Stimulus mixes seeded random samples, shifts and thresholds with directed sequences for the deadband edge, hysteresis re-enabling, saturation, clear and ignored samples.

// File: rtl/agc_pkg.sv
package agc_pkg;
  localparam int SAMPLE_W = 14;
  localparam int GAIN_W   = 4;
  localparam int SHIFT_W  = 4;
  localparam int FRAC_W   = 3;
  localparam int SQ_W     = 2 * SAMPLE_W;
  localparam int IDX_W    = $clog2(SQ_W);
  localparam int LOG_W    = IDX_W + FRAC_W;
  localparam int CFG_W    = LOG_W;
  localparam int ERR_W    = LOG_W + 3;

  typedef logic [SQ_W-1:0]          pwr_t;
  typedef logic [LOG_W-1:0]         lvl_t;
  typedef logic signed [ERR_W-1:0]  err_t;
  typedef logic [GAIN_W-1:0]        gain_t;
endpackage

// File: rtl/agc_power_det.sv
module agc_power_det
  import agc_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [SHIFT_W-1:0]  shift_i,
  output pwr_t                acc_o,
  output logic                valid_o
);
  logic [SAMPLE_W-1:0]     mag;
  pwr_t                    sq;
  logic signed [SQ_W:0]    diff;
  logic signed [SQ_W:0]    step;
  pwr_t                    acc_q;

  // magnitude of most negative sample still fits unsigned
  assign mag  = sample_i[SAMPLE_W-1] ? SAMPLE_W'(-sample_i) : sample_i;
  assign sq   = SQ_W'(mag) * SQ_W'(mag);
  assign diff = $signed({1'b0, sq}) - $signed({1'b0, acc_q});
  assign step = diff >>> shift_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      valid_o <= 1'b0;
    end else if (clear_i) begin
      acc_q   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) acc_q <= SQ_W'($signed({1'b0, acc_q}) + step);
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/agc_log2.sv
module agc_log2
  import agc_pkg::*;
(
  input  pwr_t acc_i,
  output lvl_t lvl_o
);
  logic [IDX_W-1:0]  idx;
  logic [FRAC_W-1:0] frac;

  always_comb begin
    idx = '0;
    for (int i = 0; i < SQ_W; i++)
      if (acc_i[i]) idx = IDX_W'(i);
    frac = '0;
    for (int j = 0; j < FRAC_W; j++)
      frac[FRAC_W-1-j] = (int'(idx) > j) ? acc_i[int'(idx)-1-j] : 1'b0;
  end

  assign lvl_o = (acc_i == '0) ? '0 : {idx, frac};
endmodule

// File: rtl/agc_decide.sv
module agc_decide
  import agc_pkg::*;
#(
  parameter int INIT_GAIN = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             en_i,
  input  err_t             err_i,
  input  logic [CFG_W-1:0] db_i,
  input  logic [CFG_W-1:0] hyst_i,
  input  gain_t            init_i,
  output gain_t            gain_o,
  output logic             upd_o
);
  localparam gain_t GAIN_TOP = '1;

  err_t  db_s, hy_s;
  logic  over, under, dn_rearm, up_rearm;
  logic  dn_armed, up_armed;
  gain_t gain_q;

  assign db_s     = $signed({{(ERR_W-CFG_W){1'b0}}, db_i});
  assign hy_s     = $signed({{(ERR_W-CFG_W){1'b0}}, hyst_i});
  assign over     = err_i > db_s;
  assign under    = err_i < -db_s;
  assign dn_rearm = err_i <= (db_s - hy_s);
  assign up_rearm = err_i >= (hy_s - db_s);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_q   <= GAIN_W'(INIT_GAIN);
      dn_armed <= 1'b1;
      up_armed <= 1'b1;
      upd_o    <= 1'b0;
    end else if (clear_i) begin
      gain_q   <= init_i;
      dn_armed <= 1'b1;
      up_armed <= 1'b1;
      upd_o    <= 1'b0;
    end else begin
      upd_o <= 1'b0;
      if (en_i) begin
        if (over) begin
          if (dn_armed) begin
            dn_armed <= 1'b0;
            if (gain_q != '0) begin
              gain_q <= gain_q - 1'b1;
              upd_o  <= 1'b1;
            end
          end
        end else if (dn_rearm) begin
          dn_armed <= 1'b1;
        end
        if (under) begin
          if (up_armed) begin
            up_armed <= 1'b0;
            if (gain_q != GAIN_TOP) begin
              gain_q <= gain_q + 1'b1;
              upd_o  <= 1'b1;
            end
          end
        end else if (up_rearm) begin
          up_armed <= 1'b1;
        end
      end
    end
  end

  assign gain_o = gain_q;
endmodule

// File: rtl/agc_loop.sv
module agc_loop
  import agc_pkg::*;
#(
  parameter int INIT_GAIN = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                sample_valid_i,
  input  logic [SHIFT_W-1:0]  cfg_shift_i,
  input  logic [CFG_W-1:0]    cfg_thresh_i,
  input  logic [CFG_W-1:0]    cfg_deadband_i,
  input  logic [CFG_W-1:0]    cfg_hyst_i,
  input  logic [GAIN_W-1:0]   cfg_init_gain_i,
  output logic [GAIN_W-1:0]   gain_o,
  output logic                gain_upd_o
);
  pwr_t pwr_acc;
  logic det_valid;
  lvl_t pwr_lvl;
  err_t pwr_err;

  agc_power_det u_det (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear_i),
    .valid_i  (sample_valid_i),
    .sample_i (sample_i),
    .shift_i  (cfg_shift_i),
    .acc_o    (pwr_acc),
    .valid_o  (det_valid)
  );

  agc_log2 u_log (
    .acc_i (pwr_acc),
    .lvl_o (pwr_lvl)
  );

  assign pwr_err = $signed({{(ERR_W-LOG_W){1'b0}}, pwr_lvl})
                 - $signed({{(ERR_W-CFG_W){1'b0}}, cfg_thresh_i});

  agc_decide #(.INIT_GAIN(INIT_GAIN)) u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .en_i    (det_valid),
    .err_i   (pwr_err),
    .db_i    (cfg_deadband_i),
    .hyst_i  (cfg_hyst_i),
    .init_i  (cfg_init_gain_i),
    .gain_o  (gain_o),
    .upd_o   (gain_upd_o)
  );
endmodule

// File: rtl/agc_loop_chk.sv
module agc_loop_chk
  import agc_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clear_i,
  input logic             sample_valid_i,
  input logic             det_valid,
  input pwr_t             acc,
  input err_t             err,
  input logic [CFG_W-1:0] db,
  input gain_t            gain_o,
  input logic             gain_upd_o
);
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_upd_o |-> (gain_o == $past(gain_o) + 1) || (gain_o + 1 == $past(gain_o))); // R10
  AST_HOLD_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gain_upd_o && !$past(clear_i)) |-> gain_o == $past(gain_o)); // R10
  AST_STROBE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_upd_o |-> ($past(det_valid) && !$past(clear_i))); // R5
  AST_DOWN_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gain_upd_o && gain_o < $past(gain_o)) |-> $past(err) > $signed({3'b000, $past(db)})); // R5
  AST_UP_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gain_upd_o && gain_o > $past(gain_o)) |-> $past(err) < -$signed({3'b000, $past(db)})); // R6
  AST_IDLE_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sample_valid_i && !clear_i) |=> $stable(acc)); // R11
  AST_CLEAR_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (acc == '0 && !gain_upd_o)); // R2
endmodule

bind agc_loop agc_loop_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .clear_i        (clear_i),
  .sample_valid_i (sample_valid_i),
  .det_valid      (det_valid),
  .acc            (pwr_acc),
  .err            (pwr_err),
  .db             (cfg_deadband_i),
  .gain_o         (gain_o),
  .gain_upd_o     (gain_upd_o)
);

// File: tb/agc_loop_test.sv
`timescale 1ns/1ps
module agc_loop_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clear_i = 1'b0;
  logic [13:0] sample_i = '0;
  logic        sample_valid_i = 1'b0;
  logic [3:0]  cfg_shift_i = '0;
  logic [7:0]  cfg_thresh_i = 8'd192;
  logic [7:0]  cfg_deadband_i = 8'd4;
  logic [7:0]  cfg_hyst_i = 8'd2;
  logic [3:0]  cfg_init_gain_i = 4'd8;
  logic [3:0]  gain_o;
  logic        gain_upd_o;

  int n_checks = 0;
  int n_err = 0;
  bit done = 0;

  longint m_acc = 0;
  int  m_gain = 8;
  bit  m_dn = 1, m_up = 1, m_pend = 0;
  int  exp_upd = 0;

  always #2.5 clk_i = ~clk_i;

  agc_loop uut (.*);

  function automatic int mlog(longint a);
    int p = 0;
    if (a == 0) return 0;
    while ((a >> (p + 1)) != 0) p++;
    return p * 8 + int'(((a << 3) >> p) - 8);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock: drive at falling edge, advance model, compare next falling edge
  task automatic tick(string tag, bit v, int s, bit clr);
    int err, db, hy;
    sample_i = 14'(s); sample_valid_i = v; clear_i = clr;
    exp_upd = 0;
    db = int'(cfg_deadband_i); hy = int'(cfg_hyst_i);
    if (clr) begin
      m_gain = int'(cfg_init_gain_i); m_dn = 1; m_up = 1; m_acc = 0; m_pend = 0;
    end else begin
      if (m_pend) begin
        err = mlog(m_acc) - int'(cfg_thresh_i);
        if (err > db) begin
          if (m_dn) begin
            m_dn = 0;
            if (m_gain > 0) begin m_gain--; exp_upd = 1; end
          end
        end else if (err <= db - hy) m_dn = 1;
        if (err < -db) begin
          if (m_up) begin
            m_up = 0;
            if (m_gain < 15) begin m_gain++; exp_upd = 1; end
          end
        end else if (err >= hy - db) m_up = 1;
      end
      m_pend = v;
      if (v) begin
        longint sq = longint'(s) * longint'(s);
        m_acc = m_acc + ((sq - m_acc) >>> cfg_shift_i);
      end
    end
    @(posedge clk_i); @(negedge clk_i);
    chk({tag, " gain"}, int'(gain_o), m_gain);
    chk({tag, " strobe"}, int'(gain_upd_o), exp_upd);
  endtask

  task automatic cfg(int sh, int th, int db, int hy);
    cfg_shift_i = 4'(sh); cfg_thresh_i = 8'(th);
    cfg_deadband_i = 8'(db); cfg_hyst_i = 8'(hy);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    chk("R1 gain in reset", int'(gain_o), 8);
    chk("R1 strobe in reset", int'(gain_upd_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 gain after release", int'(gain_o), 8);

    // R4/R7: deadband edge, 4096^2 -> level 192
    cfg(0, 192, 0, 0);
    tick("R2 clear", 0, 0, 1);
    tick("R7 err zero", 1, 4096, 0);
    tick("R7 err zero decide", 0, 0, 0);
    chk("R7 no step at err 0", int'(gain_o), 8);
    cfg(0, 191, 0, 0);
    tick("R4 err one", 1, 4096, 0);
    tick("R5 err one decide", 0, 0, 0);
    chk("R5 down step at err 1", int'(gain_o), 7);

    // R8 hysteresis
    cfg(0, 192, 2, 3);
    tick("R2 clear", 0, 0, 1);
    tick("R5 loud", 1, 8191, 0);
    tick("R5 loud", 1, 8191, 0);
    tick("R8 loud again", 1, 4096, 0);
    chk("R8 one step only", int'(gain_o), 7);
    tick("R8 shallow", 1, 8191, 0);
    tick("R8 blocked", 1, 3832, 0);
    chk("R8 no second step", int'(gain_o), 7);
    tick("R8 rearmed", 1, 8191, 0);
    tick("R8 step after rearm", 0, 0, 0);
    chk("R8 second step", int'(gain_o), 6);

    // R9 saturation low then high
    cfg(0, 192, 2, 0);
    cfg_init_gain_i = 4'd1;
    tick("R2 clear init 1", 0, 0, 1);
    for (int i = 0; i < 6; i++) begin
      tick("R9 low", 1, 8191, 0);
      tick("R9 low", 1, 4096, 0);
    end
    chk("R9 floor", int'(gain_o), 0);
    cfg_init_gain_i = 4'd14;
    tick("R2 clear init 14", 0, 0, 1);
    chk("R2 init load", int'(gain_o), 14);
    for (int i = 0; i < 6; i++) begin
      tick("R9 high", 1, 0, 0);
      tick("R9 high", 1, 4096, 0);
    end
    chk("R9 ceiling", int'(gain_o), 15);

    // R11 invalid samples ignored
    cfg(0, 192, 2, 0);
    cfg_init_gain_i = 4'd8;
    tick("R2 clear", 0, 0, 1);
    tick("R11 seed", 1, 4096, 0);
    for (int i = 0; i < 40; i++)
      tick("R11 idle", 0, int'($urandom_range(0, 16383)) - 8192, 0);
    chk("R11 gain held", int'(gain_o), 8);

    // R2 clear beats a sample, then slow integrator
    cfg(15, 150, 3, 1);
    for (int i = 0; i < 20; i++) tick("R3 slow fill", 1, 8000, 0);
    cfg_init_gain_i = 4'd5;
    tick("R2 clear with sample", 1, 8191, 1);
    chk("R2 loaded", int'(gain_o), 5);
    tick("R2 after clear", 1, 0, 0);
    tick("R2 empty integrator", 0, 0, 0);

    // random phase
    for (int blk = 0; blk < 40; blk++) begin
      cfg($urandom_range(0, 4), $urandom_range(140, 210), $urandom_range(0, 10),
          $urandom_range(0, 8));
      if ($urandom_range(0, 3) == 0) begin
        cfg_init_gain_i = 4'($urandom_range(0, 15));
        tick("R2 random clear", 0, 0, 1);
      end
      for (int i = 0; i < 60; i++) begin
        int k = $urandom_range(4, 13);
        int s = int'($urandom_range(0, (1 << k) - 1));
        if ($urandom_range(0, 1) == 1) s = -s;
        tick("R3 random", ($urandom_range(0, 4) != 0), s, 0);
      end
    end
    tick("R6 random tail", 0, 0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end
endmodule